// File: doc/BRIEF.md
# Frequency Window Acquisition Controller

This block helps a phase-locked loop pull its VCO into a narrow lock-in range. It runs in the reference clock domain. Each measurement cycle first loads a down-counter with a preset picked by the selected broadcast standard. For a gate interval of fixed length, the counter then takes one step down for every rising edge of the synchronized VCO signal. When the gate closes, the block compares the residual count with a lower and an upper bound. A residual above the upper bound means too few edges were counted, so the VCO is too slow and the block asks for a higher frequency. A residual below the lower bound means the VCO is too fast, so the block asks for a lower frequency. A residual between the bounds counts as locked.

After each evaluation the block holds one steering request, or none, until the next evaluation. It also holds a four-bit fine-tuning code taken from the residual and an in-window flag. When automatic muting is enabled, the in-window flag gates the audio mute. A new measurement cycle starts on the clock after every evaluation, so measurement and correction run without pause. The charge pump, the loop filter, the converter that turns the code into a current, and the VCO are outside the block.

Top module: `fwin_acq`

## Requirements
- R1: While reset is active and after it is released, before the first evaluation, `freq_up`, `freq_down`, `afc_code` and `in_window` are all 0. `audio_mute` then equals `auto_mute_en`.
- R2: The residual equals the preset of the selected standard minus the number of rising VCO edges counted inside the gate of `GATE_LEN` reference cycles. `afc_code` holds bits [3:0] of that residual.
- R3: If the residual is greater than the upper bound of the standard, `freq_up`=1, `freq_down`=0 and `in_window`=0.
- R4: If the residual is less than the lower bound of the standard, `freq_down`=1, `freq_up`=0 and `in_window`=0.
- R5: If the residual lies between the bounds, both bounds included, `in_window`=1 and both requests are 0. The two requests are never high together.
- R6: The counter stops at zero instead of wrapping. When the VCO delivers more edges than the preset, the residual is 0, `afc_code`=0 and `freq_down`=1.
- R7: `audio_mute` = `auto_mute_en` AND NOT `in_window`, at all times.
- R8: `std_sel` (value 0 to 3) indexes the preset, lower-bound and upper-bound tables; entry k of each table serves code k. The selection is sampled when a measurement cycle starts.
- R9: Measurement repeats every `GATE_LEN`+1 reference cycles with no external trigger. The outputs change only at evaluations and keep their value between them.
- R10: Only rising edges of the VCO count, after a two-flop synchronizer. For a VCO period of at least two reference cycles, the duty cycle does not affect the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| vco_in | input | 1 | Raw VCO signal, asynchronous to clk |
| std_sel | input | 2 | Broadcast standard select, indexes the tables |
| auto_mute_en | input | 1 | Enables muting while out of window |
| freq_up | output | 1 | Request to raise the VCO frequency |
| freq_down | output | 1 | Request to lower the VCO frequency |
| afc_code | output | 4 | Low four bits of the last residual |
| in_window | output | 1 | Last residual lay inside the window |
| audio_mute | output | 1 | Audio mute output |

## Verification
The bench builds the block with an 8-bit counter and a gate of 60 reference cycles. It drives the VCO with every period that divides 60, plus a stopped VCO. Any 60-cycle window therefore holds exactly 60/P rising edges whatever its phase, and the expected residual follows from plain arithmetic. The tables are chosen so that the sweep over all four standards reaches both window edges exactly, every direction, a residual of exactly zero and saturation beyond it. Pulse widths alternate between one cycle and half a period to exercise rising-edge-only counting.

// File: rtl/fwin_pkg.sv
package fwin_pkg;

  localparam int STD_COUNT = 4;
  localparam int STD_W     = 2;
  localparam int AFC_W     = 4;

  typedef enum logic [1:0] {
    WIN_BELOW  = 2'd0,
    WIN_INSIDE = 2'd1,
    WIN_ABOVE  = 2'd2
  } win_e;

endpackage

// File: rtl/fwin_edge_sync.sv
module fwin_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic meta_q;
  logic sync_q;
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;

  // R10: a detected rising edge lasts exactly one reference cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/fwin_gate_timer.sv
module fwin_gate_timer #(
  parameter int GATE_LEN = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic load_o,
  output logic count_en_o,
  output logic eval_o
);

  localparam int GW = $clog2(GATE_LEN + 1);
  localparam logic [GW-1:0] LAST = GW'(GATE_LEN);

  logic [GW-1:0] phase_q;
  logic [GW-1:0] phase_d;

  always_comb begin
    if (phase_q == LAST) phase_d = '0;
    else                 phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign load_o     = (phase_q == '0);
  assign count_en_o = !load_o;
  assign eval_o     = (phase_q == LAST);

  // R9: every evaluation is followed at once by a new cycle
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    eval_o |=> load_o);

  // R9: a cycle start is followed by a counting cycle
  a_r9_gate_open: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> count_en_o);

endmodule

// File: rtl/fwin_down_counter.sv
module fwin_down_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] preset_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_next_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_floor;

  assign at_floor = (cnt_q == '0);

  always_comb begin
    cnt_next_o = cnt_q;
    if (load_i)                  cnt_next_o = preset_i;
    else if (step_i && !at_floor) cnt_next_o = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next_o;
  end

  // R6: once at zero, the counter stays there until the next load
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (at_floor && !load_i) |=> (cnt_q == '0));

  // R2: between loads the count only falls, by at most one per cycle
  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ((cnt_q <= $past(cnt_q)) && (($past(cnt_q) - cnt_q) <= 1)));

endmodule

// File: rtl/fwin_acq.sv
module fwin_acq #(
  parameter int CNT_W    = 12,
  parameter int GATE_LEN = 1024,
  parameter logic [3:0][CNT_W-1:0] PRESET_TAB = {12'd2400, 12'd2000, 12'd1800, 12'd1500},
  parameter logic [3:0][CNT_W-1:0] LO_TAB     = {12'd1380, 12'd980,  12'd780,  12'd480},
  parameter logic [3:0][CNT_W-1:0] HI_TAB     = {12'd1420, 12'd1020, 12'd820,  12'd520}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vco_in,
  input  logic [1:0] std_sel,
  input  logic       auto_mute_en,
  output logic       freq_up,
  output logic       freq_down,
  output logic [3:0] afc_code,
  output logic       in_window,
  output logic       audio_mute
);

  import fwin_pkg::*;

  logic             rise;
  logic             load;
  logic             count_en;
  logic             eval;
  logic [CNT_W-1:0] stop_val;
  logic [CNT_W-1:0] lo_q, hi_q, lo_d, hi_d;
  win_e             cls;
  logic             up_q, dn_q, win_q;
  logic             up_d, dn_d, win_d;
  logic [AFC_W-1:0] afc_q, afc_d;

  fwin_edge_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (vco_in),
    .rise_o  (rise)
  );

  fwin_gate_timer #(.GATE_LEN(GATE_LEN)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_o     (load),
    .count_en_o (count_en),
    .eval_o     (eval)
  );

  fwin_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .preset_i   (PRESET_TAB[std_sel]),
    .step_i     (count_en && rise),
    .cnt_next_o (stop_val)
  );

  // window bounds captured together with the preset
  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (load) begin
      lo_d = LO_TAB[std_sel];
      hi_d = HI_TAB[std_sel];
    end
  end

  always_comb begin
    if (stop_val > hi_q)      cls = WIN_ABOVE;
    else if (stop_val < lo_q) cls = WIN_BELOW;
    else                      cls = WIN_INSIDE;
  end

  always_comb begin
    up_d  = up_q;
    dn_d  = dn_q;
    win_d = win_q;
    afc_d = afc_q;
    if (eval) begin
      up_d  = (cls == WIN_ABOVE);
      dn_d  = (cls == WIN_BELOW);
      win_d = (cls == WIN_INSIDE);
      afc_d = stop_val[AFC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      win_q <= 1'b0;
      afc_q <= '0;
    end else begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      up_q  <= up_d;
      dn_q  <= dn_d;
      win_q <= win_d;
      afc_q <= afc_d;
    end
  end

  assign freq_up    = up_q;
  assign freq_down  = dn_q;
  assign in_window  = win_q;
  assign afc_code   = afc_q;
  assign audio_mute = auto_mute_en & ~win_q;

  // R5: the two steering requests exclude each other
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(freq_up && freq_down));

  // R5: lock silences both requests
  a_r5_quiet_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    in_window |-> (!freq_up && !freq_down));

  // R9: outputs hold between evaluations
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !eval |=> $stable({freq_up, freq_down, afc_code, in_window}));

  // R3/R4: some request or the lock flag is set after every evaluation
  a_r3_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    eval |=> $countones({freq_up, freq_down, in_window}) == 1);

endmodule

// File: tb/test_fwin_acq.sv
module test_fwin_acq;

  localparam int CLK_PERIOD = 10;
  localparam int CW   = 8;
  localparam int GATE = 60;
  localparam int CYC  = GATE + 1;

  localparam int PRE [4] = '{50, 100, 200, 20};
  localparam int LO  [4] = '{28, 80, 170, 6};
  localparam int HI  [4] = '{32, 85, 190, 10};
  localparam int PER [12] = '{2, 3, 4, 5, 6, 10, 12, 15, 20, 30, 60, 0};

  logic       clk;
  logic       rst_n;
  logic       vco_in;
  logic [1:0] std_sel;
  logic       auto_mute_en;
  logic       freq_up, freq_down, in_window, audio_mute;
  logic [3:0] afc_code;

  int checks;
  int failures;
  int vco_per;
  int vco_hi;
  int ph;

  fwin_acq #(
    .CNT_W      (CW),
    .GATE_LEN   (GATE),
    .PRESET_TAB ({8'(PRE[3]), 8'(PRE[2]), 8'(PRE[1]), 8'(PRE[0])}),
    .LO_TAB     ({8'(LO[3]),  8'(LO[2]),  8'(LO[1]),  8'(LO[0])}),
    .HI_TAB     ({8'(HI[3]),  8'(HI[2]),  8'(HI[1]),  8'(HI[0])})
  ) i_fwin_acq (
    .clk          (clk),
    .rst_n        (rst_n),
    .vco_in       (vco_in),
    .std_sel      (std_sel),
    .auto_mute_en (auto_mute_en),
    .freq_up      (freq_up),
    .freq_down    (freq_down),
    .afc_code     (afc_code),
    .in_window    (in_window),
    .audio_mute   (audio_mute)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // VCO model: period vco_per clocks, high for vco_hi clocks, 0 = stopped
  always @(negedge clk) begin
    if (vco_per == 0) begin
      vco_in <= 1'b0;
      ph     <= 0;
    end else begin
      vco_in <= (ph < vco_hi);
      ph     <= (ph + 1 >= vco_per) ? 0 : ph + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (std=%0d per=%0d)",
               req, act, exp, std_sel, vco_per);
    end
  endtask

  task automatic run_case(input int s, input int p, input bit narrow);
    int n, stop, e_up, e_dn, e_win;
    @(posedge clk); #1;
    std_sel = 2'(s);
    vco_per = p;
    vco_hi  = (p == 0) ? 0 : (narrow ? 1 : p / 2);
    repeat (3 * CYC) @(posedge clk);
    #(CLK_PERIOD/4);
    n    = (p == 0) ? 0 : GATE / p;
    stop = (PRE[s] > n) ? PRE[s] - n : 0;
    e_up  = (stop > HI[s]) ? 1 : 0;
    e_dn  = (stop < LO[s]) ? 1 : 0;
    e_win = (e_up == 0 && e_dn == 0) ? 1 : 0;
    chk(stop == 0 ? "R6 afc" : "R2 afc", afc_code, stop % 16);
    chk("R3 freq_up", freq_up, e_up);
    chk(stop == 0 ? "R6 freq_down" : "R4 freq_down", freq_down, e_dn);
    chk("R5 in_window", in_window, e_win);
    chk("R10 duty", {28'd0, afc_code}, stop % 16);
    auto_mute_en = 1'b1; #1;
    chk("R7 mute on", audio_mute, 1 - e_win);
    auto_mute_en = 1'b0; #1;
    chk("R7 mute off", audio_mute, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    vco_per = 0; vco_hi = 0; ph = 0;
    vco_in = 1'b0; std_sel = 2'd0; auto_mute_en = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    chk("R1 up", freq_up, 0);
    chk("R1 down", freq_down, 0);
    chk("R1 afc", afc_code, 0);
    chk("R1 win", in_window, 0);
    chk("R1 mute", audio_mute, 1);
    @(negedge clk); rst_n = 1'b1;
    repeat (GATE - 5) @(posedge clk);
    #(CLK_PERIOD/4);
    chk("R1 before first eval", {freq_up, freq_down, in_window}, 0);

    // R8 sweep of every standard, R9 with no reset between cases
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 12; k++)
        run_case(s, PER[k], (k % 2) == 1);
    // R10: same periods again with the opposite duty
    for (int k = 0; k < 11; k++)
      run_case(2, PER[k], (k % 2) == 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule